// File: doc/BRIEF.md
# Data Access Fault Evaluator

This block judges a single data memory access against the current processor mode, the flags decoded from the address-space identifier, and the attributes of the translation entry that the lookup returned. From these it produces one prioritised fault code, or success. It also reports whether translation was bypassed, whether the access ran in real (untranslated-context) mode, and whether a successful access must not be cached.

Each request is presented for one cycle with `req_vld_i` high. The verdict appears on the registered outputs in the following cycle, together with a one-cycle response strobe and two update strobes. The fault-status strobe fires on any fault. The tag-capture strobe fires on translation faults. The surrounding load/store unit uses the fault code to pick the trap, and uses the strobes to capture fault status and the missing tag. The block checks the virtual address range itself, after applying the optional 32-bit address mask. Decoding of the address-space identifier happens elsewhere, and only its result flags arrive here.

Top module: `dacc_fault_chk`

## Requirements
- R1: When the misaligned flag is set, the fault code is 1 (alignment), whatever the other inputs are.
- R2: When the address mask is enabled, address bits at and above AMASK_W (32) are cleared before the range check. An address is in range when its bits [VA_W-1:IMPL_VA-1] (63:47 by default) are all zero or all one. An address out of range yields fault code 2.
- R3: `real_o` is 1 when the MMU is disabled while neither hypervisor mode nor red state is active, or when the identifier requests a real access. In that case `ctx_o` is 0. Otherwise `ctx_o` equals `ctx_i`.
- R4: In hypervisor mode, when the access is implicit or its identifier is neither as-if-user nor real, and no alignment or range fault applies, the result is fault code 0 with `bypass_o` = 1. In that case `pa_o` is the low PA_W bits of the (possibly masked) virtual address and `uncache_o` is 0.
- R5: A lookup miss, or a hit on an entry whose valid bit is clear, yields fault code 3 (miss) and raises `tag_upd_o`.
- R6: A write to an entry without write permission yields fault code 4 (protection).
- R7: An entry marked no-fault-only, accessed without the no-fault identifier flag, yields fault code 5.
- R8: A side-effect entry accessed with the no-fault identifier flag yields fault code 6.
- R9: Priority from highest to lowest is: alignment (1), range (2), bypass (success), miss (3), protection (4), no-fault-only (5), side-effect (6).
- R10: A translated access that succeeds has `pa_o` equal to the entry physical address. `uncache_o` is 1 exactly when the entry has the side-effect attribute or its physical address bit UC_BIT (39) is set.
- R11: Outputs update on the clock edge that samples `req_vld_i` high and hold until the next request. `rsp_vld_o` is high for that one cycle. `sfsr_upd_o` is high in that cycle when the code is non-zero. `tag_upd_o` is high in that cycle when the code is 3 to 6.
- R12: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld_i | input | 1 | Request strobe |
| req_wr_i | input | 1 | Access is a write |
| req_misal_i | input | 1 | Address is misaligned for the access size |
| req_amask_i | input | 1 | Address masking to 32 bits is enabled |
| req_implicit_i | input | 1 | Access uses the implicit identifier |
| req_va_i | input | VA_W | Virtual address |
| ctx_i | input | CTX_W | Context selected by the identifier |
| hpriv_i | input | 1 | Hypervisor mode |
| red_i | input | 1 | Red (reset/error) state |
| dmmu_en_i | input | 1 | Data MMU enabled |
| asi_real_i | input | 1 | Identifier requests a real access |
| asi_asif_user_i | input | 1 | Identifier is as-if-user |
| asi_nofault_i | input | 1 | Identifier is no-fault |
| tlb_hit_i | input | 1 | Lookup found an entry |
| ent_valid_i | input | 1 | Found entry is valid |
| ent_wr_i | input | 1 | Entry permits writes |
| ent_nfo_i | input | 1 | Entry is no-fault-only |
| ent_se_i | input | 1 | Entry has side effects |
| ent_pa_i | input | PA_W | Entry physical address |
| rsp_vld_o | output | 1 | Verdict valid (one cycle) |
| fault_o | output | 3 | Fault code |
| bypass_o | output | 1 | Translation bypassed |
| real_o | output | 1 | Real-mode access |
| uncache_o | output | 1 | Successful access is uncacheable |
| ctx_o | output | CTX_W | Effective context |
| pa_o | output | PA_W | Physical address |
| sfsr_upd_o | output | 1 | Fault-status update strobe |
| tag_upd_o | output | 1 | Tag-capture strobe |

## Verification
The assertions assume that the mode and identifier inputs are stable and meaningful in the cycle `req_vld_i` is high. They also assume that reset holds `req_vld_i` low, so `$past` of the misaligned flag at a response always refers to the sampled request. The stimulus drives every input on the falling edge, keeps `req_vld_i` high for exactly one cycle per request, and keeps it low throughout both reset phases. Entry attribute flags are driven even on misses, so the bench also shows that their values do not leak into a miss verdict.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

   typedef enum logic [2:0] {
      FLT_NONE  = 3'd0,
      FLT_ALIGN = 3'd1,
      FLT_RANGE = 3'd2,
      FLT_MISS  = 3'd3,
      FLT_PROT  = 3'd4,
      FLT_NFO   = 3'd5,
      FLT_SE    = 3'd6
   } flt_e;

   function automatic logic flt_is_xlat(flt_e f);
      return (f == FLT_MISS) || (f == FLT_PROT) || (f == FLT_NFO) || (f == FLT_SE);
   endfunction

endpackage

// File: rtl/dacc_va_range.sv
module dacc_va_range #(
   parameter int VA_W    = 64,
   parameter int IMPL_VA = 48,
   parameter int AMASK_W = 32,
   parameter int PA_W    = 40
) (
   input  logic [VA_W-1:0] va_i,
   input  logic            amask_i,
   output logic [PA_W-1:0] pa_cand_o,
   output logic            in_range_o
);
   localparam int HOLE_W = VA_W - IMPL_VA + 1;

   logic [VA_W-1:0] va_m;

   generate
      if (AMASK_W >= VA_W) begin : g_nomask
         assign va_m = va_i;
      end else begin : g_mask
         assign va_m = amask_i ? {{(VA_W-AMASK_W){1'b0}}, va_i[AMASK_W-1:0]} : va_i;
      end

      if (IMPL_VA >= VA_W) begin : g_full_va
         assign in_range_o = 1'b1;
      end else begin : g_hole
         logic [HOLE_W-1:0] top;
         assign top        = va_m[VA_W-1:IMPL_VA-1];
         assign in_range_o = (&top) | ~(|top);
      end
   endgenerate

   assign pa_cand_o = va_m[PA_W-1:0];

endmodule

// File: rtl/dacc_mode_sel.sv
module dacc_mode_sel #(
   parameter int CTX_W = 13
) (
   input  logic             hpriv_i,
   input  logic             red_i,
   input  logic             dmmu_en_i,
   input  logic             implicit_i,
   input  logic             asi_real_i,
   input  logic             asi_asif_user_i,
   input  logic [CTX_W-1:0] ctx_i,
   output logic             real_o,
   output logic             bypass_req_o,
   output logic [CTX_W-1:0] ctx_o
);
   logic mmu_off_real;

   assign mmu_off_real = !dmmu_en_i && !hpriv_i && !red_i;
   assign real_o       = mmu_off_real || asi_real_i;
   assign ctx_o        = real_o ? '0 : ctx_i;
   assign bypass_req_o = hpriv_i && (implicit_i || (!asi_asif_user_i && !asi_real_i));

endmodule

// File: rtl/dacc_fault_prio.sv
module dacc_fault_prio
   import dacc_pkg::*;
(
   input  logic misal_i,
   input  logic in_range_i,
   input  logic bypass_req_i,
   input  logic hit_i,
   input  logic ent_valid_i,
   input  logic wr_i,
   input  logic ent_wr_i,
   input  logic ent_nfo_i,
   input  logic ent_se_i,
   input  logic asi_nf_i,
   input  logic pa_uc_i,
   output flt_e fault_o,
   output logic bypass_o,
   output logic uncache_o
);
   always_comb begin
      fault_o   = FLT_NONE;
      bypass_o  = 1'b0;
      uncache_o = 1'b0;
      if (misal_i)
         fault_o = FLT_ALIGN;
      else if (!in_range_i)
         fault_o = FLT_RANGE;
      else if (bypass_req_i)
         bypass_o = 1'b1;
      else if (!hit_i || !ent_valid_i)
         fault_o = FLT_MISS;
      else if (wr_i && !ent_wr_i)
         fault_o = FLT_PROT;
      else if (ent_nfo_i && !asi_nf_i)
         fault_o = FLT_NFO;
      else if (ent_se_i && asi_nf_i)
         fault_o = FLT_SE;
      else
         uncache_o = ent_se_i || pa_uc_i;
   end

endmodule

// File: rtl/dacc_fault_chk.sv
module dacc_fault_chk
   import dacc_pkg::*;
#(
   parameter int VA_W    = 64,
   parameter int IMPL_VA = 48,
   parameter int AMASK_W = 32,
   parameter int PA_W    = 40,
   parameter int UC_BIT  = 39,
   parameter int CTX_W   = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_vld_i,
   input  logic             req_wr_i,
   input  logic             req_misal_i,
   input  logic             req_amask_i,
   input  logic             req_implicit_i,
   input  logic [VA_W-1:0]  req_va_i,
   input  logic [CTX_W-1:0] ctx_i,
   input  logic             hpriv_i,
   input  logic             red_i,
   input  logic             dmmu_en_i,
   input  logic             asi_real_i,
   input  logic             asi_asif_user_i,
   input  logic             asi_nofault_i,
   input  logic             tlb_hit_i,
   input  logic             ent_valid_i,
   input  logic             ent_wr_i,
   input  logic             ent_nfo_i,
   input  logic             ent_se_i,
   input  logic [PA_W-1:0]  ent_pa_i,
   output logic             rsp_vld_o,
   output logic [2:0]       fault_o,
   output logic             bypass_o,
   output logic             real_o,
   output logic             uncache_o,
   output logic [CTX_W-1:0] ctx_o,
   output logic [PA_W-1:0]  pa_o,
   output logic             sfsr_upd_o,
   output logic             tag_upd_o
);
   generate
      if (PA_W > VA_W) begin : g_bad_pa
         $error("dacc_fault_chk: PA_W must not exceed VA_W");
      end
      if (UC_BIT >= PA_W) begin : g_bad_uc
         $error("dacc_fault_chk: UC_BIT must lie inside PA_W");
      end
      if (IMPL_VA < 2 || IMPL_VA > VA_W) begin : g_bad_impl
         $error("dacc_fault_chk: IMPL_VA out of bounds");
      end
      if (AMASK_W < 1) begin : g_bad_mask
         $error("dacc_fault_chk: AMASK_W must be positive");
      end
   endgenerate

   logic [PA_W-1:0]  pa_cand;
   logic             in_range;
   logic             real_d;
   logic             bypass_req;
   logic [CTX_W-1:0] ctx_d;
   flt_e             fault_d;
   logic             bypass_d;
   logic             uncache_d;
   logic [PA_W-1:0]  pa_d;

   dacc_va_range #(
      .VA_W    (VA_W),
      .IMPL_VA (IMPL_VA),
      .AMASK_W (AMASK_W),
      .PA_W    (PA_W)
   ) u_range (
      .va_i       (req_va_i),
      .amask_i    (req_amask_i),
      .pa_cand_o  (pa_cand),
      .in_range_o (in_range)
   );

   dacc_mode_sel #(.CTX_W(CTX_W)) u_mode (
      .hpriv_i         (hpriv_i),
      .red_i           (red_i),
      .dmmu_en_i       (dmmu_en_i),
      .implicit_i      (req_implicit_i),
      .asi_real_i      (asi_real_i),
      .asi_asif_user_i (asi_asif_user_i),
      .ctx_i           (ctx_i),
      .real_o          (real_d),
      .bypass_req_o    (bypass_req),
      .ctx_o           (ctx_d)
   );

   dacc_fault_prio u_prio (
      .misal_i      (req_misal_i),
      .in_range_i   (in_range),
      .bypass_req_i (bypass_req),
      .hit_i        (tlb_hit_i),
      .ent_valid_i  (ent_valid_i),
      .wr_i         (req_wr_i),
      .ent_wr_i     (ent_wr_i),
      .ent_nfo_i    (ent_nfo_i),
      .ent_se_i     (ent_se_i),
      .asi_nf_i     (asi_nofault_i),
      .pa_uc_i      (ent_pa_i[UC_BIT]),
      .fault_o      (fault_d),
      .bypass_o     (bypass_d),
      .uncache_o    (uncache_d)
   );

   assign pa_d = bypass_d ? pa_cand : ent_pa_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld_o  <= 1'b0;
         fault_o    <= 3'd0;
         bypass_o   <= 1'b0;
         real_o     <= 1'b0;
         uncache_o  <= 1'b0;
         ctx_o      <= '0;
         pa_o       <= '0;
         sfsr_upd_o <= 1'b0;
         tag_upd_o  <= 1'b0;
      end else begin
         rsp_vld_o  <= req_vld_i;
         sfsr_upd_o <= req_vld_i && (fault_d != FLT_NONE);
         tag_upd_o  <= req_vld_i && flt_is_xlat(fault_d);
         if (req_vld_i) begin
            fault_o   <= fault_d;
            bypass_o  <= bypass_d;
            real_o    <= real_d;
            uncache_o <= uncache_d;
            ctx_o     <= ctx_d;
            pa_o      <= pa_d;
         end
      end
   end

endmodule

// File: rtl/dacc_fault_chk_sva.sv
module dacc_fault_chk_sva #(
   parameter int CTX_W = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_misal_i,
   input logic             rsp_vld_o,
   input logic [2:0]       fault_o,
   input logic             bypass_o,
   input logic             real_o,
   input logic             uncache_o,
   input logic [CTX_W-1:0] ctx_o,
   input logic             sfsr_upd_o,
   input logic             tag_upd_o
);
   // R1: a misaligned request always reports the alignment code
   a_r1_misal_first: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld_o && $past(req_misal_i)) |-> (fault_o == 3'd1));

   // R3: real mode forces the context to zero
   a_r3_real_ctx_zero: assert property (@(posedge clk) disable iff (!rst_n)
      real_o |-> (ctx_o == '0));

   // R4: a bypassed access is clean and cacheable
   a_r4_bypass_clean: assert property (@(posedge clk) disable iff (!rst_n)
      bypass_o |-> (fault_o == 3'd0 && !uncache_o));

   // R5: tag capture only with a translation fault and a status update
   a_r5_tag_xlat_only: assert property (@(posedge clk) disable iff (!rst_n)
      tag_upd_o |-> (sfsr_upd_o && fault_o >= 3'd3 && fault_o <= 3'd6));

   // R9: the code never leaves the defined set
   a_r9_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld_o |-> (fault_o <= 3'd6));

   // R10: uncacheable only marks a successful translated access
   a_r10_uc_success: assert property (@(posedge clk) disable iff (!rst_n)
      uncache_o |-> (fault_o == 3'd0 && !bypass_o));

   // R11: status strobe exactly on faulting responses
   a_r11_sfsr_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld_o |-> (sfsr_upd_o == (fault_o != 3'd0)));

   // R11: no strobe without a response
   a_r11_no_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_vld_o |-> (!sfsr_upd_o && !tag_upd_o));

endmodule

bind dacc_fault_chk dacc_fault_chk_sva #(.CTX_W(CTX_W)) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_misal_i (req_misal_i),
   .rsp_vld_o   (rsp_vld_o),
   .fault_o     (fault_o),
   .bypass_o    (bypass_o),
   .real_o      (real_o),
   .uncache_o   (uncache_o),
   .ctx_o       (ctx_o),
   .sfsr_upd_o  (sfsr_upd_o),
   .tag_upd_o   (tag_upd_o)
);

// File: tb/dacc_fault_chk_tb_top.sv
`timescale 1ns/1ps
module dacc_fault_chk_tb_top;
   localparam int VA_W  = 64;
   localparam int PA_W  = 40;
   localparam int CTX_W = 13;
   localparam logic [CTX_W-1:0] CTX_V = 13'h155;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic req_vld, req_wr, req_misal, req_amask, req_implicit;
   logic [VA_W-1:0] req_va;
   logic [CTX_W-1:0] ctx;
   logic hpriv, red, dmmu_en, asi_real, asi_asif, asi_nf;
   logic hit, ent_valid, ent_wr, ent_nfo, ent_se;
   logic [PA_W-1:0] ent_pa;
   logic rsp_vld, bypass, real_m, uncache, sfsr_upd, tag_upd;
   logic [2:0] fault;
   logic [CTX_W-1:0] ctx_out;
   logic [PA_W-1:0] pa;

   dacc_fault_chk dut_i (
      .clk(clk), .rst_n(rst_n), .req_vld_i(req_vld), .req_wr_i(req_wr),
      .req_misal_i(req_misal), .req_amask_i(req_amask), .req_implicit_i(req_implicit),
      .req_va_i(req_va), .ctx_i(ctx), .hpriv_i(hpriv), .red_i(red),
      .dmmu_en_i(dmmu_en), .asi_real_i(asi_real), .asi_asif_user_i(asi_asif),
      .asi_nofault_i(asi_nf), .tlb_hit_i(hit), .ent_valid_i(ent_valid),
      .ent_wr_i(ent_wr), .ent_nfo_i(ent_nfo), .ent_se_i(ent_se), .ent_pa_i(ent_pa),
      .rsp_vld_o(rsp_vld), .fault_o(fault), .bypass_o(bypass), .real_o(real_m),
      .uncache_o(uncache), .ctx_o(ctx_out), .pa_o(pa), .sfsr_upd_o(sfsr_upd),
      .tag_upd_o(tag_upd)
   );

   typedef struct packed {
      logic misal, am, im, hp, red, dm, ar, au, nf, hit, val, ew, nfo, se, wr;
      logic [1:0] vs;
      logic puc;
      logic [2:0] ef;
      logic eb, er, eu;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t TBL [NV] = '{
      '{0,0,0,0,0,1,0,0,0,1,1,1,0,0,0,2'd0,0,3'd0,0,0,0},
      '{1,0,0,0,0,1,0,0,0,0,0,0,0,0,0,2'd1,0,3'd1,0,0,0},
      '{0,0,0,0,0,1,0,0,0,0,0,0,0,0,0,2'd1,0,3'd2,0,0,0},
      '{0,1,0,0,0,1,0,0,0,1,1,1,0,0,1,2'd1,0,3'd0,0,0,0},
      '{0,0,0,0,0,1,0,0,0,1,1,1,0,0,0,2'd3,0,3'd2,0,0,0},
      '{0,0,0,0,0,1,0,0,0,1,1,1,0,0,0,2'd2,0,3'd0,0,0,0},
      '{0,0,0,0,0,0,0,0,0,1,1,1,0,0,0,2'd0,0,3'd0,0,1,0},
      '{0,0,0,0,1,0,0,0,0,1,1,1,0,0,0,2'd0,0,3'd0,0,0,0},
      '{0,0,0,0,0,1,1,0,0,1,1,1,0,0,0,2'd0,0,3'd0,0,1,0},
      '{0,0,0,1,0,1,0,0,0,0,0,0,0,0,0,2'd0,0,3'd0,1,0,0},
      '{0,0,0,1,0,1,0,1,0,0,0,0,0,0,0,2'd0,0,3'd3,0,0,0},
      '{0,0,1,1,0,1,0,1,0,0,0,0,0,0,0,2'd0,0,3'd0,1,0,0},
      '{0,0,0,1,0,1,1,0,0,0,0,0,0,0,0,2'd0,0,3'd3,0,1,0},
      '{1,0,0,1,0,1,0,0,0,0,0,0,0,0,0,2'd0,0,3'd1,0,0,0},
      '{0,0,0,0,0,1,0,0,0,1,0,1,1,1,0,2'd0,0,3'd3,0,0,0},
      '{0,0,0,0,0,1,0,0,0,1,1,0,0,0,1,2'd0,0,3'd4,0,0,0},
      '{0,0,0,0,0,1,0,0,0,1,1,0,1,0,1,2'd0,0,3'd4,0,0,0},
      '{0,0,0,0,0,1,0,0,0,1,1,1,1,0,0,2'd0,0,3'd5,0,0,0},
      '{0,0,0,0,0,1,0,0,1,1,1,1,1,0,0,2'd0,0,3'd0,0,0,0},
      '{0,0,0,0,0,1,0,0,1,1,1,1,1,1,0,2'd0,0,3'd6,0,0,0},
      '{0,0,0,0,0,1,0,0,0,1,1,1,0,1,0,2'd0,0,3'd0,0,0,1},
      '{0,0,0,0,0,1,0,0,0,1,1,1,0,0,0,2'd0,1,3'd0,0,0,1},
      '{0,0,0,0,0,1,0,0,0,1,1,0,0,0,1,2'd0,1,3'd4,0,0,0},
      '{0,0,0,1,0,1,0,0,0,1,1,1,0,1,0,2'd0,0,3'd0,1,0,0},
      '{0,0,0,1,0,0,0,0,0,0,0,0,0,0,0,2'd0,0,3'd0,1,0,0}
   };

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   function automatic logic [VA_W-1:0] va_of(logic [1:0] s);
      case (s)
         2'd0:    return 64'h0000_0000_1234_5678;
         2'd1:    return 64'h0000_8000_0000_1000;
         2'd2:    return 64'hFFFF_8000_0000_2000;
         default: return 64'h0123_0000_0000_3000;
      endcase
   endfunction

   function automatic string tag_of(vec_t v);
      case (v.ef)
         3'd1: return "R1";
         3'd2: return "R2";
         3'd3: return "R5";
         3'd4: return "R6";
         3'd5: return "R7";
         3'd6: return "R8";
         default: return v.eb ? "R4" : (v.eu ? "R10" : (v.er ? "R3" : "R9"));
      endcase
   endfunction

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      req_vld = 0; req_wr = 0; req_misal = 0; req_amask = 0; req_implicit = 0;
      req_va = '0; ctx = CTX_V; hpriv = 0; red = 0; dmmu_en = 1; asi_real = 0;
      asi_asif = 0; asi_nf = 0; hit = 0; ent_valid = 0; ent_wr = 0; ent_nfo = 0;
      ent_se = 0; ent_pa = '0;
   endtask

   task automatic load_vec(vec_t v);
      req_misal = v.misal; req_amask = v.am; req_implicit = v.im; hpriv = v.hp;
      red = v.red; dmmu_en = v.dm; asi_real = v.ar; asi_asif = v.au; asi_nf = v.nf;
      hit = v.hit; ent_valid = v.val; ent_wr = v.ew; ent_nfo = v.nfo; ent_se = v.se;
      req_wr = v.wr; req_va = va_of(v.vs);
      ent_pa = v.puc ? 40'h80_0000_1000 : 40'h00_0000_1000;
   endtask

   // drive at falling edge, result registered at next rising edge,
   // sampled at the falling edge after it
   task automatic fire();
      req_vld = 1'b1;
      @(negedge clk);
      req_vld = 1'b0;
   endtask

   task automatic check_reset_state(string tag);
      check(tag, "rsp_vld", rsp_vld, 0);
      check(tag, "fault", fault, 0);
      check(tag, "bypass", bypass, 0);
      check(tag, "real", real_m, 0);
      check(tag, "uncache", uncache, 0);
      check(tag, "ctx", ctx_out, 0);
      check(tag, "pa", pa, 0);
      check(tag, "sfsr", sfsr_upd, 0);
      check(tag, "tag_upd", tag_upd, 0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      repeat (4) @(negedge clk);
      // R12: reset state
      check_reset_state("R12");
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         load_vec(TBL[i]);
         fire();
         check(tag_of(TBL[i]), "rsp_vld", rsp_vld, 1);
         check(tag_of(TBL[i]), "fault", fault, TBL[i].ef);
         check(tag_of(TBL[i]), "bypass", bypass, TBL[i].eb);
         check(tag_of(TBL[i]), "real", real_m, TBL[i].er);
         check(tag_of(TBL[i]), "uncache", uncache, TBL[i].eu);
         check("R3", "ctx", ctx_out, TBL[i].er ? 0 : CTX_V);
         check("R11", "sfsr", sfsr_upd, TBL[i].ef != 0);
         check("R11", "tag_upd", tag_upd, TBL[i].ef >= 3);
      end

      // R11: one-cycle strobes, held verdict after a miss
      idle_inputs();
      req_va = va_of(2'd0);
      fire();
      check("R11", "miss sfsr", sfsr_upd, 1);
      check("R5", "miss tag", tag_upd, 1);
      @(negedge clk);
      check("R11", "rsp after", rsp_vld, 0);
      check("R11", "sfsr after", sfsr_upd, 0);
      check("R11", "tag after", tag_upd, 0);
      check("R11", "fault hold", fault, 3);
      // R11: inputs changed without a request do not move the outputs
      req_misal = 1'b1;
      @(negedge clk);
      check("R11", "fault no req", fault, 3);

      // R4: bypass address, unmasked and masked
      idle_inputs();
      hpriv = 1'b1;
      req_va = 64'h0000_00AB_CDEF_0123;
      fire();
      check("R4", "pa unmasked", pa, 40'hAB_CDEF_0123);
      req_amask = 1'b1;
      fire();
      check("R4", "pa masked", pa, 40'h00_CDEF_0123);
      check("R2", "masked ok", fault, 0);

      // R10: translated success takes entry address
      idle_inputs();
      req_va = va_of(2'd0);
      hit = 1; ent_valid = 1; ent_wr = 1;
      ent_pa = 40'h12_3456_7000;
      fire();
      check("R10", "pa entry", pa, 40'h12_3456_7000);
      check("R10", "cacheable", uncache, 0);

      // R12: reset mid-run clears held outputs
      idle_inputs();
      req_misal = 1'b1;
      fire();
      check("R1", "misal pre-reset", fault, 1);
      rst_n = 1'b0;
      @(negedge clk);
      check_reset_state("R12");
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule